// File: doc/BRIEF.md
# Rate-1/3 Turbo Encoder with Table-Driven Interleaver

This block turns a message of N bits into a rate-1/3 turbo codeword. Message bits stream into a block buffer over a valid/ready input. A start pulse sets the block length N. The encoder then walks index i from 0 to N-1 and emits one output symbol per step. Each symbol carries the systematic bit, the parity bit of a first recursive encoder fed in natural order, and the parity bit of a second, identical encoder fed with the permuted bit. The permuted bit is read from the buffer at the address that a permutation table holds for position i.

Software writes the permutation table once, before any block is encoded. The table stays in place and is reused for every later block of the same size. Both constituent encoders use feedback 1 + D^2 + D^3 and feed-forward 1 + D + D^3. After the data steps, both encoders are driven back to the all-zero state over three tail steps, and each tail step carries four tail bits. The output is a valid/ready stream with backpressure and a flag on the final symbol. Block size can change at runtime, up to a parameter maximum.

Top module: `turbo_enc_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: While idle, each accepted input bit is stored at the next buffer position, starting at 0 after reset and after every accepted start. `in_ready` is 0 from the cycle after an accepted start until the block's final symbol has been produced.
- R3: A start is accepted only while idle and only with `blk_len` between 1 and MAX_N. Any other start produces no output and leaves `in_ready` at 1.
- R4: Symbol i (0 <= i < N) has `out_x` = b_i, which is the bit stored at position i.
- R5: On a data step, `out_y` is the parity of the first encoder fed with b_i. The encoder's state s = (s1,s2,s3) starts at zero on every block. Its feedback is a = u ^ s2 ^ s3 and its parity is a ^ s1 ^ s3. The state then becomes (a, s1, s2).
- R6: On a data step, `out_z` is the parity, by the same rule, of the second encoder fed with b'_i = b[T[i]], where T is the permutation table written through `tbl_we`/`tbl_waddr`/`tbl_wdata`.
- R7: Three tail symbols follow the N data symbols, with `out_tail` = 1. On each tail step, each encoder takes u = s2 ^ s3. The first encoder gives `out_x`/`out_y` and the second gives `out_x2`/`out_z`. Both states are zero after the third tail step. `out_x2` is 0 on data symbols.
- R8: A block emits exactly N+3 symbols, and `out_last` is 1 only on the final tail symbol.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and all symbol outputs hold unchanged.
- R10: The permutation table keeps its contents across blocks, so a second block of the same size, loaded without rewriting the table, uses the same permutation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Permutation table write strobe |
| tbl_waddr | input | AW | Table position i to write |
| tbl_wdata | input | AW | Source address T[i] for position i |
| in_valid | input | 1 | Message bit valid |
| in_ready | output | 1 | Message bit can be accepted |
| in_bit | input | 1 | Message bit |
| start | input | 1 | Begin encoding the buffered block |
| blk_len | input | LW | Block length N, sampled with an accepted start |
| out_valid | output | 1 | Output symbol valid |
| out_ready | input | 1 | Sink accepts the output symbol |
| out_x | output | 1 | Systematic bit (first encoder tail bit on tail steps) |
| out_y | output | 1 | First encoder parity |
| out_x2 | output | 1 | Second encoder tail systematic bit, 0 on data steps |
| out_z | output | 1 | Second encoder parity |
| out_tail | output | 1 | Symbol is a termination step |
| out_last | output | 1 | Final symbol of the block |

## Verification
The assertions assume that every table entry for positions below N holds an address below N, and that exactly N bits were loaded before the start. Under those conditions, a final symbol always finds both encoder states at zero. The stimulus writes a random permutation of 0..N-1 before a new block size is used, and loads exactly N bits before each start. It drives `out_ready` at random, and only ever steps outside these assumptions with starts that the block must ignore.

// File: rtl/turbo_enc_pkg.sv
package turbo_enc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mode_t;

    typedef struct packed {
        logic x;
        logic y;
        logic x2;
        logic z;
        logic tail;
        logic last;
    } sym_t;

    // feedback taps D^2 and D^3; s[0] is the first delay
    function automatic logic rsc_feedback(input logic u, input logic [2:0] s);
        return u ^ s[1] ^ s[2];
    endfunction

    // forward taps 1, D and D^3
    function automatic logic rsc_parity(input logic a, input logic [2:0] s);
        return a ^ s[0] ^ s[2];
    endfunction

    // input bit that cancels the feedback and drives the state to zero
    function automatic logic rsc_flush_bit(input logic [2:0] s);
        return s[1] ^ s[2];
    endfunction

endpackage

// File: rtl/turbo_rsc.sv
module turbo_rsc
    import turbo_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       step,
    input  logic       term,
    input  logic       u,
    output logic       sys,
    output logic       par,
    output logic [2:0] st
);
    logic u_eff;
    logic fb;

    always_comb begin
        u_eff = term ? rsc_flush_bit(st) : u;
        fb    = rsc_feedback(u_eff, st);
        sys   = u_eff;
        par   = rsc_parity(fb, st);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st <= '0;
        end else if (step) begin
            st <= {st[1], st[0], fb};
        end
    end
endmodule

// File: rtl/turbo_bitbuf.sv
module turbo_bitbuf #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wbit,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic          rbit_a,
    output logic          rbit_b
);
    localparam int SLOTS = 2 ** AW;

    logic mem [SLOTS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wbit;
        end
    end

    assign rbit_a = mem[raddr_a];
    assign rbit_b = mem[raddr_b];
endmodule

// File: rtl/turbo_perm_tbl.sv
module turbo_perm_tbl #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [AW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [AW-1:0] rdata
);
    localparam int SLOTS = 2 ** AW;

    logic [AW-1:0] tbl [SLOTS];

    always_ff @(posedge clk) begin
        if (we) begin
            tbl[waddr] <= wdata;
        end
    end

    assign rdata = tbl[raddr];
endmodule

// File: rtl/turbo_enc_top.sv
module turbo_enc_top
    import turbo_enc_pkg::*;
#(
    parameter  int MAX_N = 1024,
    localparam int AW    = $clog2(MAX_N),
    localparam int LW    = $clog2(MAX_N + 1),
    localparam int CW    = $clog2(MAX_N + 3)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tbl_we,
    input  logic [AW-1:0] tbl_waddr,
    input  logic [AW-1:0] tbl_wdata,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_bit,
    input  logic          start,
    input  logic [LW-1:0] blk_len,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_x,
    output logic          out_y,
    output logic          out_x2,
    output logic          out_z,
    output logic          out_tail,
    output logic          out_last
);
    localparam int NENC = 2;

    mode_t         mode;
    logic [LW-1:0] load_cnt;
    logic [LW-1:0] len_q;
    logic [CW-1:0] idx;
    sym_t          sym_q;
    sym_t          nxt_sym;

    logic          start_ok;
    logic          in_fire;
    logic          advance;
    logic          in_tail;
    logic          last_step;

    logic [AW-1:0] perm_addr;
    logic          bit_nat;
    logic          bit_perm;

    logic [NENC-1:0] enc_u;
    logic [NENC-1:0] enc_sys;
    logic [NENC-1:0] enc_par;
    logic [2:0]      enc_st [NENC];
    logic [2:0]      st_a;
    logic [2:0]      st_b;

    assign start_ok  = (mode == ST_IDLE) && start && (blk_len != '0)
                       && (blk_len <= LW'(MAX_N));
    assign in_ready  = (mode == ST_IDLE) && (load_cnt < LW'(MAX_N));
    assign in_fire   = in_valid && in_ready;
    assign advance   = (mode == ST_RUN) && (!out_valid || out_ready);
    assign in_tail   = idx >= CW'(len_q);
    assign last_step = idx == (CW'(len_q) + CW'(2));

    turbo_bitbuf #(.AW(AW)) u_buf (
        .clk     (clk),
        .we      (in_fire),
        .waddr   (load_cnt[AW-1:0]),
        .wbit    (in_bit),
        .raddr_a (idx[AW-1:0]),
        .raddr_b (perm_addr),
        .rbit_a  (bit_nat),
        .rbit_b  (bit_perm)
    );

    turbo_perm_tbl #(.AW(AW)) u_tbl (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_waddr),
        .wdata (tbl_wdata),
        .raddr (idx[AW-1:0]),
        .rdata (perm_addr)
    );

    assign enc_u = {bit_perm, bit_nat};

    for (genvar g = 0; g < NENC; g++) begin : g_enc
        turbo_rsc u_rsc (
            .clk   (clk),
            .rst   (rst),
            .clear (start_ok),
            .step  (advance),
            .term  (in_tail),
            .u     (enc_u[g]),
            .sys   (enc_sys[g]),
            .par   (enc_par[g]),
            .st    (enc_st[g])
        );
    end

    assign st_a = enc_st[0];
    assign st_b = enc_st[1];

    always_comb begin
        nxt_sym.x    = enc_sys[0];
        nxt_sym.y    = enc_par[0];
        nxt_sym.x2   = in_tail ? enc_sys[1] : 1'b0;
        nxt_sym.z    = enc_par[1];
        nxt_sym.tail = in_tail;
        nxt_sym.last = last_step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= ST_IDLE;
            load_cnt  <= '0;
            len_q     <= '0;
            idx       <= '0;
            out_valid <= 1'b0;
            sym_q     <= '0;
        end else begin
            if (in_fire) begin
                load_cnt <= load_cnt + LW'(1);
            end
            case (mode)
                ST_IDLE: begin
                    if (start_ok) begin
                        mode     <= ST_RUN;
                        len_q    <= blk_len;
                        idx      <= '0;
                        load_cnt <= '0;
                    end
                end
                ST_RUN: begin
                    if (advance) begin
                        idx <= idx + CW'(1);
                        if (last_step) begin
                            mode <= ST_IDLE;
                        end
                    end
                end
                default: mode <= ST_IDLE;
            endcase
            if (advance) begin
                out_valid <= 1'b1;
                sym_q     <= nxt_sym;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    assign out_x    = sym_q.x;
    assign out_y    = sym_q.y;
    assign out_x2   = sym_q.x2;
    assign out_z    = sym_q.z;
    assign out_tail = sym_q.tail;
    assign out_last = sym_q.last;
endmodule

// File: rtl/turbo_enc_chk.sv
module turbo_enc_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_acc,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_x,
    input logic       out_y,
    input logic       out_x2,
    input logic       out_z,
    input logic       out_tail,
    input logic       out_last,
    input logic [2:0] st_a,
    input logic [2:0] st_b
);
    logic [5:0] sym_bits;
    assign sym_bits = {out_x, out_y, out_x2, out_z, out_tail, out_last};

    // R9: a stalled symbol must not move
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(sym_bits)));

    // R8: the closing flag only appears on a tail step
    p_last_in_tail_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> out_tail);

    // R7: both encoders are back at zero once the closing symbol exists
    p_term_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> (st_a == 3'd0 && st_b == 3'd0));

    // R7: second tail systematic bit is silent on data steps
    p_data_x2_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_tail) |-> !out_x2);

    // R2: no message input while a block is being encoded
    p_busy_r2: assert property (@(posedge clk) disable iff (rst)
        start_acc |=> !in_ready);
endmodule

bind turbo_enc_top turbo_enc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_acc (start_ok),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_x     (out_x),
    .out_y     (out_y),
    .out_x2    (out_x2),
    .out_z     (out_z),
    .out_tail  (out_tail),
    .out_last  (out_last),
    .st_a      (st_a),
    .st_b      (st_b)
);

// File: tb/turbo_enc_top_bench.sv
`timescale 1ns/1ps
module turbo_enc_top_bench;
    localparam int MAX_N = 40;
    localparam int AW    = $clog2(MAX_N);
    localparam int LW    = $clog2(MAX_N + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          tbl_we;
    logic [AW-1:0] tbl_waddr;
    logic [AW-1:0] tbl_wdata;
    logic          in_valid;
    logic          in_ready;
    logic          in_bit;
    logic          start;
    logic [LW-1:0] blk_len;
    logic          out_valid;
    logic          out_ready;
    logic          out_x, out_y, out_x2, out_z, out_tail, out_last;

    int checks = 0;
    int errors = 0;

    bit msg  [64];
    int perm [64];
    bit ex_x [67];
    bit ex_y [67];
    bit ex_x2[67];
    bit ex_z [67];

    always #2.5 clk = ~clk;

    turbo_enc_top #(.MAX_N(MAX_N)) u_turbo_enc_top (
        .clk(clk), .rst(rst),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
        .start(start), .blk_len(blk_len),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_x(out_x), .out_y(out_y), .out_x2(out_x2), .out_z(out_z),
        .out_tail(out_tail), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one step of the constituent code; returns {sys, par}
    function automatic logic [1:0] model_step(input bit term, input bit u,
                                              inout logic [2:0] s);
        bit ue, a, p;
        ue = term ? (s[1] ^ s[2]) : u;
        a  = ue ^ s[1] ^ s[2];
        p  = a ^ s[0] ^ s[2];
        s  = {s[1], s[0], a};
        return {ue, p};
    endfunction

    function automatic void build_expected(input int n);
        logic [2:0] s1 = 3'd0;
        logic [2:0] s2 = 3'd0;
        logic [1:0] r1, r2;
        for (int i = 0; i < n + 3; i++) begin
            bit t = (i >= n);
            r1 = model_step(t, t ? 1'b0 : msg[i], s1);
            r2 = model_step(t, t ? 1'b0 : msg[perm[i]], s2);
            ex_x[i]  = r1[1];
            ex_y[i]  = r1[0];
            ex_x2[i] = t ? r2[1] : 1'b0;
            ex_z[i]  = r2[0];
        end
    endfunction

    task automatic load_perm(input int n);
        for (int i = 0; i < n; i++) perm[i] = i;
        for (int i = n - 1; i > 0; i--) begin
            int j = $urandom_range(i, 0);
            int t = perm[i];
            perm[i] = perm[j];
            perm[j] = t;
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tbl_we    = 1'b1;
            tbl_waddr = AW'(i);
            tbl_wdata = AW'(perm[i]);
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic load_bits(input int n);
        int i = 0;
        while (i < n) begin
            @(negedge clk);
            if ($urandom_range(3, 0) == 0) begin
                in_valid = 1'b0;
            end else begin
                msg[i]   = 1'($urandom_range(1, 0));
                in_valid = 1'b1;
                in_bit   = msg[i];
                check(in_ready, "R2", "in_ready while loading", int'(in_ready), 1);
                i++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_block(input int n, input int stall_pct);
        int   k = 0;
        int   guard = 0;
        bit   held = 1'b0;
        logic [5:0] held_val = '0;
        logic [5:0] cur;
        build_expected(n);
        @(negedge clk);
        start   = 1'b1;
        blk_len = LW'(n);
        @(negedge clk);
        start = 1'b0;
        check(!in_ready, "R2", "in_ready after start", int'(in_ready), 0);
        while (k < n + 3 && guard < 2000) begin
            bit rdy;
            guard++;
            cur = {out_valid, out_x, out_y, out_x2, out_z, out_last};
            if (held) begin
                check(cur == held_val, "R9", "stalled symbol changed",
                      int'(cur), int'(held_val));
                held = 1'b0;
            end
            rdy = ($urandom_range(99, 0) >= stall_pct);
            out_ready = rdy;
            if (out_valid && rdy) begin
                bit ok;
                ok = (out_x == ex_x[k]) && (out_y == ex_y[k]) &&
                     (out_x2 == ex_x2[k]) && (out_z == ex_z[k]);
                if (k < n)
                    check(ok, "R4 R5 R6", $sformatf("data symbol %0d {x,y,x2,z}", k),
                          int'({out_x, out_y, out_x2, out_z}),
                          int'({ex_x[k], ex_y[k], ex_x2[k], ex_z[k]}));
                else
                    check(ok, "R7", $sformatf("tail symbol %0d {x,y,x2,z}", k),
                          int'({out_x, out_y, out_x2, out_z}),
                          int'({ex_x[k], ex_y[k], ex_x2[k], ex_z[k]}));
                check(out_tail == (k >= n), "R7", "tail flag",
                      int'(out_tail), int'(k >= n));
                check(out_last == (k == n + 2), "R8", "last flag",
                      int'(out_last), int'(k == n + 2));
                k++;
            end else if (out_valid) begin
                held     = 1'b1;
                held_val = cur;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(k == n + 3, "R8", "symbols received", k, n + 3);
        repeat (2) @(negedge clk);
        check(!out_valid, "R8", "no symbol after last", int'(out_valid), 0);
        check(in_ready, "R2", "in_ready back after block", int'(in_ready), 1);
    endtask

    task automatic bad_start(input int len);
        bit quiet = 1'b1;
        @(negedge clk);
        start   = 1'b1;
        blk_len = LW'(len);
        @(negedge clk);
        start = 1'b0;
        out_ready = 1'b1;
        repeat (6) begin
            @(negedge clk);
            if (out_valid || !in_ready) quiet = 1'b0;
        end
        out_ready = 1'b0;
        check(quiet, "R3", $sformatf("start with length %0d ignored", len),
              int'(quiet), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        rst = 1'b1; tbl_we = 1'b0; tbl_waddr = '0; tbl_wdata = '0;
        in_valid = 1'b0; in_bit = 1'b0; start = 1'b0; blk_len = '0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
        check(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);

        // R10: two blocks share one table load
        load_perm(13);
        load_bits(13);
        run_block(13, 30);
        load_bits(13);
        run_block(13, 0);

        // R3: illegal lengths
        bad_start(0);
        bad_start(MAX_N + 1);

        // boundary sizes
        load_perm(MAX_N);
        load_bits(MAX_N);
        run_block(MAX_N, 50);
        load_perm(1);
        load_bits(1);
        run_block(1, 20);

        // random sizes and tables
        for (int b = 0; b < 6; b++) begin
            int n = $urandom_range(MAX_N, 2);
            load_perm(n);
            load_bits(n);
            run_block(n, $urandom_range(70, 0));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule